// File: doc/BRIEF.md
# Page-Mode Burst Controller for Multiplexed-Address DRAM

This block turns cache-line refill requests into read bursts on an asynchronous DRAM. The DRAM has one address bus that carries the row address and then the column address. A request is a word address offered with a valid/ready handshake. The controller splits the address into a row and a column. It places the row on the pins and drops the row strobe, then walks four columns of an aligned group while the row stays open. Each column is latched with the column strobe, and one data word comes back per column, each marked by a one-cycle valid pulse.

All DRAM timing is counted in controller clock cycles through parameters: row-to-data time, precharge time, column cycle and refresh interval. The first word arrives one cycle after the row-to-data time, and each later word follows one column cycle after the one before it. With the default values this gives the 5-3-3-3 beat schedule and fourteen cycles per burst. A refresh timer asks for a strobe cycle with only the row strobe active, on a row counter that advances by one each time. That request takes the next idle slot, ahead of any waiting request, but it never breaks into a burst.

Top module: `pgd_ctrl`

## Requirements
- R1: While reset is high and after it is released, dram_ras_n, dram_cas_n and dram_oe_n are 1, rd_valid is 0 and req_ready is 0. req_ready first rises T_PRE cycles after the release.
- R2: In the first cycle that dram_ras_n is 0 after an accepted request, dram_addr equals req_addr[2*ADDR_W-1:ADDR_W], which is the row.
- R3: For beat i (0..3), dram_addr equals the request column with its two low bits replaced by i, that is {req_addr[ADDR_W-1:2], i[1:0]}, in every cycle that dram_cas_n is 0. dram_cas_n is 0 only while dram_ras_n is 0.
- R4: Each accepted request returns exactly four rd_valid pulses. Each rd_data is the value of dram_dq sampled during that beat's column strobe, and rd_last is 1 on the fourth pulse only.
- R5: If acceptance is cycle 0, rd_valid is 1 in cycles T_RAC+1, T_RAC+1+T_COL, T_RAC+1+2*T_COL and T_RAC+1+3*T_COL, and 0 in every other cycle up to the last beat. Per beat, dram_cas_n is low for the T_COL-1 cycles just before that beat's rd_valid cycle.
- R6: Before every falling edge of dram_ras_n, dram_ras_n has been high for at least T_PRE cycles. Two consecutive falling edges are at least T_RAC+T_PRE cycles apart.
- R7: After every T_REF cycles a refresh becomes due. It is served as a strobe cycle in which dram_ras_n is low for exactly T_RAC cycles and dram_cas_n stays high. Its row comes from a counter that starts at 0 after reset and advances by one, modulo 2^ADDR_W, per refresh.
- R8: A due refresh is served before a request that waits in the same idle cycle. A burst is never split: its four beats keep the spacing of R5 even when a refresh falls due during the burst.
- R9: req_ready is 1 only while the controller is idle and no refresh is due, and it is 0 while dram_ras_n is 0. With req_valid at 0 no column strobe and no rd_valid occur.
- R10: dram_oe_n is 0 exactly in the cycles where dram_cas_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Refill request offered |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_addr | input | 2*ADDR_W | Word address: row in the upper half, column in the lower half |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | DATA_W | Returned word |
| rd_last | output | 1 | Marks the fourth word of a burst |
| dram_addr | output | ADDR_W | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable for the read direction, active low |
| dram_dq | input | DATA_W | Read data from the DRAM |

## Verification
Two functions meet in one cycle: the refresh timer reaching its interval and a refill request waiting at an idle slot. A refresh can also fall due while a burst is running. Both cases are provoked by a long back-to-back stream in which req_valid never drops. Over the stream the timer expires several times, in different phases of the burst and precharge sequence. The collisions are judged at the pins: every burst must keep its exact beat offsets and data, every strobe cycle without a column strobe must carry the next refresh row and last exactly T_RAC cycles, and at least two such refreshes must land between the stream's bursts.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

  typedef enum logic [2:0] {
    S_INIT = 3'd0,
    S_IDLE = 3'd1,
    S_ROW  = 3'd2,
    S_CSET = 3'd3,
    S_CLOW = 3'd4,
    S_REF  = 3'd5,
    S_PRE  = 3'd6
  } pgd_state_t;

endpackage

// File: rtl/pgd_wait_cnt.sv
module pgd_wait_cnt #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgd_refresh.sv
module pgd_refresh #(
  parameter int T_REF = 256,
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pending,
  output logic [ROW_W-1:0] row
);

  localparam int CW = (T_REF > 1) ? $clog2(T_REF) : 1;
  localparam logic [CW-1:0] LAST = CW'(T_REF - 1);

  logic [CW-1:0] tick_q;
  logic          wrap;

  assign wrap = (tick_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      tick_q <= wrap ? '0 : tick_q + 1'b1;
      if (wrap) begin
        pending <= 1'b1;
      end else if (ack) begin
        pending <= 1'b0;
      end
      if (ack) begin
        row <= row + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pgd_ctrl.sv
module pgd_ctrl #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int T_RAC  = 4,
  parameter int T_PRE  = 3,
  parameter int T_COL  = 3,
  parameter int T_REF  = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2*ADDR_W-1:0]   req_addr,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_last,
  output logic [ADDR_W-1:0]     dram_addr,
  output logic                  dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_oe_n,
  input  logic [DATA_W-1:0]     dram_dq
);
  import pgd_pkg::*;

  localparam int BURST  = 4;
  localparam int BEAT_W = $clog2(BURST);
  localparam int MAXT   = T_RAC + T_PRE + T_COL;
  localparam int CNT_W  = $clog2(MAXT + 1) + 1;
  localparam logic [CNT_W-1:0] LD_ROW = CNT_W'(T_RAC - T_COL - 1);
  localparam logic [CNT_W-1:0] LD_COL = CNT_W'(T_COL - 2);
  localparam logic [CNT_W-1:0] LD_PRE = CNT_W'(T_PRE - 1);
  localparam logic [CNT_W-1:0] LD_REF = CNT_W'(T_RAC - 1);

  pgd_state_t           state_q, state_d;
  logic                 ras_q, ras_d, cas_q, cas_d, oe_q, oe_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [ADDR_W-1:0]    colb_q, colb_d;
  logic [BEAT_W-1:0]    beat_q, beat_d;
  logic [DATA_W-1:0]    data_q, data_d;
  logic                 vld_q, vld_d, last_q, last_d;
  logic                 cnt_ld, cnt_zero;
  logic [CNT_W-1:0]     cnt_val;
  logic                 ref_pend, ref_ack;
  logic [ADDR_W-1:0]    ref_row;
  logic                 beat_end;

  pgd_wait_cnt #(.W(CNT_W), .RST_VAL(T_PRE - 1)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_ld),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  pgd_refresh #(.T_REF(T_REF), .ROW_W(ADDR_W)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .ack     (ref_ack),
    .pending (ref_pend),
    .row     (ref_row)
  );

  assign beat_end = (beat_q == BEAT_W'(BURST - 1));

  always_comb begin
    state_d = state_q;
    ras_d   = ras_q;
    cas_d   = cas_q;
    oe_d    = oe_q;
    addr_d  = addr_q;
    colb_d  = colb_q;
    beat_d  = beat_q;
    data_d  = data_q;
    vld_d   = 1'b0;
    last_d  = 1'b0;
    cnt_ld  = 1'b0;
    cnt_val = '0;
    ref_ack = 1'b0;
    case (state_q)
      S_INIT: begin
        if (cnt_zero) state_d = S_IDLE;
      end
      S_IDLE: begin
        if (ref_pend) begin
          state_d = S_REF;
          ras_d   = 1'b0;
          addr_d  = ref_row;
          cnt_ld  = 1'b1;
          cnt_val = LD_REF;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          state_d = S_ROW;
          ras_d   = 1'b0;
          addr_d  = req_addr[2*ADDR_W-1:ADDR_W];
          colb_d  = {req_addr[ADDR_W-1:BEAT_W], {BEAT_W{1'b0}}};
          beat_d  = '0;
          cnt_ld  = 1'b1;
          cnt_val = LD_ROW;
        end
      end
      S_ROW: begin
        if (cnt_zero) begin
          state_d = S_CSET;
          addr_d  = {colb_q[ADDR_W-1:BEAT_W], beat_q};
        end
      end
      S_CSET: begin
        state_d = S_CLOW;
        cas_d   = 1'b0;
        oe_d    = 1'b0;
        cnt_ld  = 1'b1;
        cnt_val = LD_COL;
      end
      S_CLOW: begin
        if (cnt_zero) begin
          data_d = dram_dq;
          vld_d  = 1'b1;
          last_d = beat_end;
          cas_d  = 1'b1;
          oe_d   = 1'b1;
          if (beat_end) begin
            state_d = S_PRE;
            ras_d   = 1'b1;
            cnt_ld  = 1'b1;
            cnt_val = LD_PRE;
          end else begin
            state_d = S_CSET;
            beat_d  = beat_q + 1'b1;
            addr_d  = {colb_q[ADDR_W-1:BEAT_W], beat_q + 1'b1};
          end
        end
      end
      S_REF: begin
        if (cnt_zero) begin
          state_d = S_PRE;
          ras_d   = 1'b1;
          cnt_ld  = 1'b1;
          cnt_val = LD_PRE;
        end
      end
      S_PRE: begin
        if (cnt_zero) state_d = S_IDLE;
      end
      default: state_d = S_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_INIT;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      oe_q    <= 1'b1;
      addr_q  <= '0;
      colb_q  <= '0;
      beat_q  <= '0;
      data_q  <= '0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
      oe_q    <= oe_d;
      addr_q  <= addr_d;
      colb_q  <= colb_d;
      beat_q  <= beat_d;
      data_q  <= data_d;
      vld_q   <= vld_d;
      last_q  <= last_d;
    end
  end

  assign req_ready  = (state_q == S_IDLE) && !ref_pend;
  assign rd_valid   = vld_q;
  assign rd_data    = data_q;
  assign rd_last    = last_q;
  assign dram_addr  = addr_q;
  assign dram_ras_n = ras_q;
  assign dram_cas_n = cas_q;
  assign dram_oe_n  = oe_q;

endmodule

// File: rtl/pgd_checker.sv
module pgd_checker #(
  parameter int ADDR_W = 14,
  parameter int T_RAC  = 4,
  parameter int T_PRE  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              rd_last,
  input logic [ADDR_W-1:0] dram_addr,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_oe_n
);

  logic [7:0] hi_cnt, rc_cnt;
  logic       prev_ras, seen_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      rc_cnt    <= '0;
      prev_ras  <= 1'b1;
      seen_fall <= 1'b0;
    end else begin
      prev_ras <= dram_ras_n;
      if (dram_ras_n) hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1;
      else            hi_cnt <= '0;
      if (!dram_ras_n && prev_ras) begin
        rc_cnt    <= 8'd1;
        seen_fall <= 1'b1;
      end else begin
        rc_cnt <= (rc_cnt == 8'hFF) ? rc_cnt : rc_cnt + 1'b1;
      end
    end
  end

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && prev_ras) |-> (hi_cnt >= 8'(T_PRE))); // R6
  AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && prev_ras && seen_fall) |-> (rc_cnt >= 8'(T_RAC + T_PRE))); // R6
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n); // R3
  AST_COL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && !$past(dram_cas_n)) |-> $stable(dram_addr)); // R3
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid); // R4
  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> !req_ready); // R9
  AST_OE_WITH_CAS: assert property (@(posedge clk) disable iff (rst)
    !dram_oe_n |-> !dram_cas_n); // R10

endmodule

bind pgd_ctrl pgd_checker #(.ADDR_W(ADDR_W), .T_RAC(T_RAC), .T_PRE(T_PRE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .rd_last    (rd_last),
  .dram_addr  (dram_addr),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_oe_n  (dram_oe_n)
);

// File: tb/sim_pgd_ctrl.sv
`timescale 1ns/1ps
module sim_pgd_ctrl;
  localparam int AW    = 14;
  localparam int DW    = 32;
  localparam int T_RAC = 4;
  localparam int T_PRE = 3;
  localparam int T_COL = 3;
  localparam int T_REF = 256;
  localparam int LIMIT = 100000;

  // {row, requested column, expected aligned column base}
  localparam logic [3*AW-1:0] VEC [0:5] = '{
    {14'h0000, 14'h0000, 14'h0000},
    {14'h3FFF, 14'h3FFF, 14'h3FFC},
    {14'h1234, 14'h0ABD, 14'h0ABC},
    {14'h0001, 14'h0002, 14'h0000},
    {14'h2AAA, 14'h1555, 14'h1554},
    {14'h1555, 14'h2AA8, 14'h2AA8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2*AW-1:0] req_addr = '0;
  logic rd_valid, rd_last;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_oe_n;
  logic [DW-1:0] dram_dq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pgd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RAC(T_RAC), .T_PRE(T_PRE),
             .T_COL(T_COL), .T_REF(T_REF)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n), .dram_dq(dram_dq)
  );

  // DRAM model: latch row on RAS fall, answer row/column while strobed
  logic [AW-1:0] lat_row = '0;
  logic          m_prev_ras = 1'b1;
  always @(posedge clk) begin
    if (!dram_ras_n && m_prev_ras) lat_row <= dram_addr;
    m_prev_ras <= dram_ras_n;
  end
  assign dram_dq = (!dram_cas_n && !dram_oe_n) ? {2'b00, lat_row, 2'b00, dram_addr}
                                               : {DW{1'b1}};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin monitor for refresh cycles and precharge spacing
  logic [AW-1:0] fall_row;
  int  lo_len = 0, hi_len = 0, ref_cnt = 0;
  logic [AW-1:0] exp_ref = '0;
  bit  cas_seen = 1'b0, mon_prev = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!dram_ras_n) begin
        if (mon_prev) begin
          chk(hi_len >= T_PRE, "R6 precharge before RAS fall", hi_len, T_PRE);
          fall_row = dram_addr;
          cas_seen = 1'b0;
          lo_len   = 1;
        end else begin
          lo_len++;
        end
        if (!dram_cas_n) cas_seen = 1'b1;
      end else begin
        if (!mon_prev) begin
          if (!cas_seen) begin
            chk(fall_row == exp_ref, "R7 refresh row", fall_row, exp_ref);
            chk(lo_len == T_RAC, "R7 refresh strobe length", lo_len, T_RAC);
            exp_ref = exp_ref + 1'b1;
            ref_cnt++;
          end
          hi_len = 1;
        end else begin
          hi_len++;
        end
      end
      mon_prev = dram_ras_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_req(input logic [AW-1:0] row, input logic [AW-1:0] col,
                         input logic [AW-1:0] colb, input bit keep);
    req_valid = 1'b1;
    req_addr  = {row, col};
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int k = 1; k <= T_RAC + 1 + 3 * T_COL; k++) begin
      @(negedge clk);
      if (k == 1 && !keep) req_valid = 1'b0;
      if (k == 1) begin
        chk(!dram_ras_n && dram_addr == row, "R2 row on pins", dram_addr, row);
        chk(!req_ready, "R9 ready low when busy", req_ready, 0);
      end
      for (int b = 0; b < 4; b++) begin
        int vk;
        vk = T_RAC + 1 + b * T_COL;
        if (k == vk) begin
          chk(rd_valid, "R5 beat timing", rd_valid, 1);
          chk(rd_data == {2'b00, row, 2'b00, colb | AW'(b)}, "R4 beat data",
              rd_data, {2'b00, row, 2'b00, colb | AW'(b)});
          chk(rd_last == (b == 3), "R4 last flag", rd_last, b == 3);
        end
        if (k < vk && k >= vk - (T_COL - 1)) begin
          chk(!dram_cas_n && dram_addr == (colb | AW'(b)), "R3 column strobe",
              {dram_cas_n, dram_addr}, {1'b0, colb | AW'(b)});
          chk(!dram_oe_n, "R10 output enable", dram_oe_n, 0);
        end
      end
      if (k != T_RAC + 1 && k != T_RAC + 1 + T_COL && k != T_RAC + 1 + 2 * T_COL &&
          k != T_RAC + 1 + 3 * T_COL)
        chk(!rd_valid, "R5 no stray beat", rd_valid, 0);
    end
  endtask

  initial begin
    int r0;
    bit bad;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_oe_n, "R1 strobes idle in reset",
        {dram_ras_n, dram_cas_n, dram_oe_n}, 3'b111);
    chk(!rd_valid && !req_ready, "R1 outputs quiet in reset", {rd_valid, req_ready}, 0);
    rst = 1'b0;
    for (int i = 1; i <= T_PRE; i++) begin
      @(negedge clk);
      if (i < T_PRE) chk(!req_ready, "R1 precharge after reset", req_ready, 0);
      else           chk(req_ready, "R1 ready after precharge", req_ready, 1);
      chk(dram_ras_n && dram_cas_n, "R1 strobes high after reset",
          {dram_ras_n, dram_cas_n}, 2'b11);
    end

    for (int v = 0; v < 6; v++) begin
      run_req(VEC[v][3*AW-1:2*AW], VEC[v][2*AW-1:AW], VEC[v][AW-1:0], 1'b0);
    end

    // R9: with no request offered no column access happens
    req_valid = 1'b0;
    req_addr  = {14'h0F0F, 14'h0F0F};
    bad = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!dram_cas_n || rd_valid) bad = 1'b1;
    end
    chk(!bad, "R9 idle without request", bad, 0);

    // R8: back-to-back stream with valid never dropped, crossing refreshes
    r0 = ref_cnt;
    for (int i = 0; i < 40; i++) begin
      run_req(AW'(i * 37 + 5), AW'(i * 11), AW'(i * 11) & ~AW'(3), 1'b1);
    end
    req_valid = 1'b0;
    chk(ref_cnt - r0 >= 2, "R8 refresh between held requests", ref_cnt - r0, 2);
    chk(ref_cnt >= 3, "R7 periodic refresh seen", ref_cnt, 3);

    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule